// File: doc/BRIEF.md
# Transparent B-Channel Byte Transmitter

This block sends bytes from a 128-entry transmit FIFO onto a 64 kbit/s B channel exactly as software wrote them. No flag bytes, no check sequence and no zero-bit insertion are applied. Each byte goes out most significant bit first, one bit for every cycle in which the line-side bit strobe is high. When no message is running, the line carries an all-ones fill pattern.

Software loads bytes through a write port and then pulses a start command. The block then asks for more data by setting a sticky "ready" flag. The flag is set once the number of free FIFO locations exceeds the selected threshold of 16, 32 or 64 bytes. Software answers by writing up to one threshold's worth of bytes and pulsing start again. If the FIFO is empty when a new byte is needed, the block drops back to fill and raises a sticky underrun flag. It stays in fill until software refills the FIFO and pulses start. The response window is the threshold divided by the line rate: 64 bytes at 64 kbit/s gives 8 ms.

Top module: `rawbit_tx`

## Requirements
- R1: While sending, each cycle with `bitEn` high sets `txBit` at that clock edge to the next bit of the FIFO data, bit 7 of each byte first and bit 0 last, with no bits added or altered. In cycles with `bitEn` low, `txBit` holds its value.
- R2: Until a start command has moved the block into sending, `txBit` stays 1 whatever bytes are written and whatever `bitEn` does.
- R3: `irqReady` is set one clock after the ready request is armed while the free FIFO locations (128 minus the stored byte count) are strictly more than the threshold. `thrSel` encodes the threshold as 0 = 16, 1 = 32, 2 or 3 = 64.
- R4: The ready request is armed by reset, by every `startCmd` pulse and by every underrun. It is disarmed when it sets `irqReady`, so each arming produces at most one setting.
- R5: When `bitEn` is high at a byte boundary while sending and the FIFO is empty, the block returns to fill. At that edge `txBit` becomes 1 and `irqUnderrun` is set.
- R6: After an underrun, writes alone do not restart transmission. The bytes already written go out only after a new `startCmd`.
- R7: A `startCmd` pulse while the FIFO is empty starts nothing and raises no underrun. The line stays at 1.
- R8: A write while the FIFO holds 128 bytes is dropped. Only the first 128 bytes are later sent.
- R9: `irqClr` is write-one-to-clear, bit 0 for `irqReady` and bit 1 for `irqUnderrun`. A clear each flag in the same cycle as that flag's setting event leaves the flag set.
- R10: During reset, `txBit` is 1 and both interrupt flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write one byte into the FIFO |
| wrData | input | 8 | Byte to write |
| startCmd | input | 1 | Transmit-start command pulse |
| thrSel | input | 2 | Threshold select: 0 = 16, 1 = 32, 2 or 3 = 64 |
| irqClr | input | 2 | Write-one-to-clear: bit 0 ready, bit 1 underrun |
| bitEn | input | 1 | Line bit-slot strobe |
| txBit | output | 1 | Serial line output |
| irqReady | output | 1 | Sticky FIFO-ready flag |
| irqUnderrun | output | 1 | Sticky transmit-underrun flag |

## Verification
Two events can fall in the same cycle: software clearing the underrun flag, and the line strobe reaching an empty byte boundary, which sets that flag. The bench provokes this by raising `irqClr[1]` together with the bit strobe that follows the last of 128 bytes. It then expects `irqUnderrun` to read 1 on the next sample and the line to be back at fill. A scoreboard that predicts every line bit also confirms that the two bytes written past a full FIFO never appear on the line.

// File: rtl/rawbit_pkg.sv
package rawbit_pkg;

  // Strobes from the control unit to the datapath
  typedef struct packed {
    logic load;   // pop the head byte and emit its first bit
    logic shift;  // emit the next bit of the current byte
    logic fill;   // force the idle fill level
  } txStrobe_t;

  function automatic int thresholdOf(input logic [1:0] sel,
                                     input int lo, input int mid, input int hi);
    case (sel)
      2'd0:    return lo;
      2'd1:    return mid;
      default: return hi;
    endcase
  endfunction

endpackage

// File: rtl/rawbit_datapath.sv
module rawbit_datapath
  import rawbit_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int WIDTH = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1,
  localparam int BW = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [WIDTH-1:0] wrData,
  input  txStrobe_t        strobe,
  output logic [CW-1:0]    fifoCount,
  output logic             byteDone,
  output logic             txBit
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wrPtr, rdPtr;
  logic [WIDTH-1:0] shReg;
  logic [BW-1:0]    bitsLeft;
  logic             wrAccept;

  assign wrAccept = wrEn && (fifoCount != CW'(DEPTH));
  assign byteDone = (bitsLeft == '0);

  always_ff @(posedge clk) begin
    if (wrAccept) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      fifoCount <= '0;
    end else begin
      if (wrAccept)    wrPtr <= wrPtr + 1'b1;
      if (strobe.load) rdPtr <= rdPtr + 1'b1;
      fifoCount <= fifoCount + CW'(wrAccept) - CW'(strobe.load);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txBit    <= 1'b1;
      shReg    <= '0;
      bitsLeft <= '0;
    end else if (strobe.load) begin
      txBit    <= mem[rdPtr][WIDTH-1];
      shReg    <= mem[rdPtr] << 1;
      bitsLeft <= BW'(WIDTH - 1);
    end else if (strobe.shift) begin
      txBit    <= shReg[WIDTH-1];
      shReg    <= shReg << 1;
      bitsLeft <= bitsLeft - 1'b1;
    end else if (strobe.fill) begin
      txBit    <= 1'b1;
      bitsLeft <= '0;
    end
  end

endmodule

// File: rtl/rawbit_ctrl.sv
module rawbit_ctrl
  import rawbit_pkg::*;
#(
  parameter int DEPTH   = 128,
  parameter int THR_LO  = 16,
  parameter int THR_MID = 32,
  parameter int THR_HI  = 64,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          startCmd,
  input  logic          bitEn,
  input  logic [1:0]    thrSel,
  input  logic [1:0]    irqClr,
  input  logic [CW-1:0] fifoCount,
  input  logic          byteDone,
  output txStrobe_t     strobe,
  output logic          sending,
  output logic          irqReady,
  output logic          irqUnderrun
);

  logic          underrunEv, startGo, armed, readyCond;
  logic [CW-1:0] vacancy, thrVal;

  assign vacancy   = CW'(DEPTH) - fifoCount;
  assign thrVal    = CW'(thresholdOf(thrSel, THR_LO, THR_MID, THR_HI));
  assign readyCond = vacancy > thrVal;
  assign startGo   = !sending && startCmd && (fifoCount != '0);

  always_comb begin
    strobe     = '0;
    underrunEv = 1'b0;
    if (bitEn) begin
      if (!sending)               strobe.fill  = 1'b1;
      else if (!byteDone)         strobe.shift = 1'b1;
      else if (fifoCount != '0)   strobe.load  = 1'b1;
      else begin
        strobe.fill = 1'b1;
        underrunEv  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sending     <= 1'b0;
      armed       <= 1'b1;
      irqReady    <= 1'b0;
      irqUnderrun <= 1'b0;
    end else begin
      if (startGo)         sending <= 1'b1;
      else if (underrunEv) sending <= 1'b0;

      if (startCmd || underrunEv)  armed <= 1'b1;
      else if (armed && readyCond) armed <= 1'b0;

      irqReady    <= (irqReady && !irqClr[0]) || (armed && readyCond);
      irqUnderrun <= (irqUnderrun && !irqClr[1]) || underrunEv;
    end
  end

endmodule

// File: rtl/rawbit_tx.sv
module rawbit_tx
  import rawbit_pkg::*;
#(
  parameter int DEPTH   = 128,
  parameter int WIDTH   = 8,
  parameter int THR_LO  = 16,
  parameter int THR_MID = 32,
  parameter int THR_HI  = 64,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [WIDTH-1:0] wrData,
  input  logic             startCmd,
  input  logic [1:0]       thrSel,
  input  logic [1:0]       irqClr,
  input  logic             bitEn,
  output logic             txBit,
  output logic             irqReady,
  output logic             irqUnderrun
);

  txStrobe_t     strobe;
  logic [CW-1:0] fifoCount;
  logic          byteDone;
  logic          sending;

  rawbit_ctrl #(
    .DEPTH(DEPTH), .THR_LO(THR_LO), .THR_MID(THR_MID), .THR_HI(THR_HI)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .startCmd(startCmd), .bitEn(bitEn),
    .thrSel(thrSel), .irqClr(irqClr), .fifoCount(fifoCount),
    .byteDone(byteDone), .strobe(strobe), .sending(sending),
    .irqReady(irqReady), .irqUnderrun(irqUnderrun)
  );

  rawbit_datapath #(.DEPTH(DEPTH), .WIDTH(WIDTH)) uPath (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .strobe(strobe), .fifoCount(fifoCount), .byteDone(byteDone),
    .txBit(txBit)
  );

endmodule

// File: rtl/rawbit_tx_chk.sv
module rawbit_tx_chk #(
  parameter int DEPTH = 128,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rstN,
  input logic          bitEn,
  input logic          startCmd,
  input logic [1:0]    irqClr,
  input logic          txBit,
  input logic          irqUnderrun,
  input logic          sending,
  input logic          byteDone,
  input logic [CW-1:0] fifoCount
);

  logic emptyHit;
  assign emptyHit = sending && bitEn && byteDone && (fifoCount == '0);

  p_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    (sending && !bitEn) |=> $stable(txBit));

  p_idle_fill_r2: assert property (@(posedge clk) disable iff (!rstN)
    !sending |-> txBit);

  p_underrun_r5: assert property (@(posedge clk) disable iff (!rstN)
    emptyHit |=> (!sending && irqUnderrun && txBit));

  p_empty_start_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!sending && startCmd && (fifoCount == '0)) |=> !sending);

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rstN)
    fifoCount <= CW'(DEPTH));

  p_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    (irqClr[1] && !emptyHit) |=> !irqUnderrun);

endmodule

bind rawbit_tx rawbit_tx_chk #(.DEPTH(DEPTH)) uChk (
  .clk(clk), .rstN(rstN), .bitEn(bitEn), .startCmd(startCmd),
  .irqClr(irqClr), .txBit(txBit), .irqUnderrun(irqUnderrun),
  .sending(sending), .byteDone(byteDone), .fifoCount(fifoCount)
);

// File: tb/rawbit_tx_test.sv
`timescale 1ns/1ps
module rawbit_tx_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic       startCmd = 1'b0;
  logic [1:0] thrSel = 2'd0;
  logic [1:0] irqClr = 2'b00;
  logic       bitEn = 1'b0;
  logic       txBit, irqReady, irqUnderrun;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  bit expQ [$];      // scoreboard: expected line bits
  bit active = 1'b0; // model: message in progress
  bit expUnder = 1'b0;

  always #2.5 clk = ~clk;

  rawbit_tx uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .startCmd(startCmd), .thrSel(thrSel), .irqClr(irqClr),
    .bitEn(bitEn), .txBit(txBit), .irqReady(irqReady),
    .irqUnderrun(irqUnderrun)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard on each line bit slot
  always begin
    bit e;
    @(posedge clk);
    if (bitEn && rstN) begin
      if (active && expQ.size() != 0) e = expQ.pop_front();
      else if (active) begin
        e = 1'b1;
        active = 1'b0;
        expUnder = 1'b1;
      end else e = 1'b1;
      @(negedge clk);
      check(txBit == e, "R1/R2 line bit", int'(txBit), int'(e));
    end
  end

  task automatic writeByte(input logic [7:0] b);
    @(negedge clk);
    wrEn = 1'b1;
    wrData = b;
    if (expQ.size() / 8 < 128)
      for (int i = 7; i >= 0; i--) expQ.push_back(b[i]);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic startTx();
    @(negedge clk);
    startCmd = 1'b1;
    @(negedge clk);
    startCmd = 1'b0;
    if (expQ.size() != 0) active = 1'b1;
  endtask

  task automatic sendBits(input int n, input logic [1:0] clr = 2'b00);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bitEn = 1'b1;
      if (i == n - 1) irqClr = clr;
      @(negedge clk);
      bitEn = 1'b0;
      irqClr = 2'b00;
    end
  endtask

  task automatic clearFlags(input logic [1:0] m);
    @(negedge clk);
    irqClr = m;
    @(negedge clk);
    irqClr = 2'b00;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // R10: reset state
    repeat (3) @(negedge clk);
    check(txBit == 1'b1, "R10 txBit", int'(txBit), 1);
    check(irqReady == 1'b0, "R10 irqReady", int'(irqReady), 0);
    check(irqUnderrun == 1'b0, "R10 irqUnderrun", int'(irqUnderrun), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(irqReady == 1'b1, "R4 armed by reset", int'(irqReady), 1);
    clearFlags(2'b01);
    check(irqReady == 1'b0, "R9 clear ready", int'(irqReady), 0);

    // R7: start with empty FIFO
    startTx();
    @(negedge clk);
    check(irqReady == 1'b1, "R4 armed by start", int'(irqReady), 1);
    check(irqUnderrun == 1'b0, "R7 no underrun", int'(irqUnderrun), 0);
    sendBits(4);
    clearFlags(2'b01);

    // R2 then R1 and R5
    writeByte(8'hA5); writeByte(8'h3C); writeByte(8'h7E); writeByte(8'h00);
    sendBits(3);
    startTx();
    sendBits(32);
    check(irqUnderrun == 1'b0, "R5 no early underrun", int'(irqUnderrun), 0);
    sendBits(1);
    check(irqUnderrun == 1'b1, "R5 underrun flag", int'(irqUnderrun), 1);
    check(expUnder == 1'b1, "R5 model underrun", int'(expUnder), 1);

    // R6: writes alone do not restart
    writeByte(8'h81); writeByte(8'h5A);
    sendBits(5);
    check(irqUnderrun == 1'b1, "R6 flag sticky", int'(irqUnderrun), 1);
    clearFlags(2'b10);
    check(irqUnderrun == 1'b0, "R9 clear underrun", int'(irqUnderrun), 0);
    startTx();
    sendBits(17);
    check(irqUnderrun == 1'b1, "R6 resent then underrun", int'(irqUnderrun), 1);
    clearFlags(2'b11);

    // R3: threshold 64 (thrSel = 2)
    thrSel = 2'd2;
    for (int i = 0; i < 70; i++) writeByte(8'(i * 3 + 1));
    clearFlags(2'b01);
    check(irqReady == 1'b0, "R3 ready cleared", int'(irqReady), 0);
    startTx();
    sendBits(48);
    check(irqReady == 1'b0, "R3 vacancy 64 not above 64", int'(irqReady), 0);
    sendBits(1);
    check(irqReady == 1'b0, "R3 one cycle latency", int'(irqReady), 0);
    @(negedge clk);
    check(irqReady == 1'b1, "R3 vacancy 65 above 64", int'(irqReady), 1);
    sendBits(70 * 8 - 49 + 1);
    clearFlags(2'b11);

    // R3: threshold 16 (thrSel = 0)
    thrSel = 2'd0;
    for (int i = 0; i < 113; i++) writeByte(8'(255 - i));
    clearFlags(2'b01);
    startTx();
    sendBits(8);
    check(irqReady == 1'b0, "R3 vacancy 16 not above 16", int'(irqReady), 0);
    sendBits(1);
    @(negedge clk);
    check(irqReady == 1'b1, "R3 vacancy 17 above 16", int'(irqReady), 1);
    sendBits(113 * 8 - 9 + 1);
    clearFlags(2'b11);

    // R8 full FIFO, R9 clear colliding with underrun
    for (int i = 0; i < 130; i++) writeByte(8'(i * 7));
    startTx();
    sendBits(1024);
    check(irqUnderrun == 1'b0, "R8 no underrun at 128", int'(irqUnderrun), 0);
    sendBits(1, 2'b10);
    check(irqUnderrun == 1'b1, "R9 set wins over clear", int'(irqUnderrun), 1);
    check(txBit == 1'b1, "R5 fill after underrun", int'(txBit), 1);
    sendBits(8);
    clearFlags(2'b10);
    check(irqUnderrun == 1'b0, "R9 clear after collision", int'(irqUnderrun), 0);

    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule